// File: doc/BRIEF.md
# Seven-Segment Digit Row Decoder with Zero Suppression

This block drives a row of seven-segment digits from packed BCD codes. Each digit's 4-bit code becomes seven active-low segment drives. A lamp-test control lights every segment on every digit. A per-digit blank control switches one digit dark. A ripple chain switches off zeros that carry no value: leading zeros in the integer part and trailing zeros in the fraction part.

The row is split by the parameter `INT_DIGITS`. Digits with index below `INT_DIGITS` form the integer part, and their chain runs from index 0 (leftmost) rightward. The remaining digits form the fraction part, and their chain runs from the rightmost digit leftward. With the chain heads held low, the code sequence 0,3,0 | 0,8,0 therefore shows as "30.08".

Each digit has a ripple-out line that both reports suppression and takes part in blanking. When `WIRED_AND` is set, that line models a shared pin. An external low on the digit's blank input pulls it low, and the low then travels along the chain to the next digit. All outputs are registered and follow their inputs one clock later.

Top module: `sevseg_blank_top`

## Requirements
- R1: Digit k takes its code from `bcd_i[4k+3:4k]` and drives `seg_n_o[7k+6:7k]`, with bit 0 = segment a through bit 6 = segment g, and 0 meaning lit. Codes 0..9 give the usual glyphs, with active-high lit masks 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex). Outputs follow the inputs one clock later.
- R2: Codes 10..15 turn all seven segments off (7F), unless lamp test is active.
- R3: While `lamp_test_n` is low, every segment of every digit is lit (00), whatever the code, blank or ripple inputs are. The digit's own ripple-out is high; with `WIRED_AND`, it reads low only where that digit's `blank_n` is low. Lamp test takes priority over every other control.
- R4: While lamp test is inactive and `blank_n[k]` is low, digit k is fully off (7F) for any code.
- R5: A digit whose ripple-in is low and whose code is 0 is fully off, and its `rbo_n_o` bit is low.
- R6: A digit whose ripple-in is high and whose code is 0 shows "0" (40 active-low), and its `rbo_n_o` bit is high.
- R7: Integer chain: digit 0 takes ripple-in from `rbi_int_n`. Each integer digit k>0 takes it from the ripple-out of digit k-1.
- R8: Fraction chain: digit DIGITS-1 takes ripple-in from `rbi_frac_n`. Each fraction digit k takes it from the ripple-out of digit k+1.
- R9: With `WIRED_AND`=1, `rbo_n_o[k]` is the AND of the digit's own ripple-out and `blank_n[k]`. A blank forced on one digit therefore suppresses a zero in the next digit of its chain.
- R10: During reset, all segments are off (7F) and all `rbo_n_o` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bcd_i | input | 4*DIGITS | Packed BCD codes, digit 0 in the low nibble |
| lamp_test_n | input | 1 | Lamp test, active low |
| blank_n | input | DIGITS | Per-digit blank command, active low |
| rbi_int_n | input | 1 | Ripple-in for the head of the integer chain |
| rbi_frac_n | input | 1 | Ripple-in for the head of the fraction chain |
| seg_n_o | output | 7*DIGITS | Active-low segments, 7 per digit |
| rbo_n_o | output | DIGITS | Per-digit ripple-out (the shared pin level) |

## Verification
A wrong chain decision shows at the ports one clock after the inputs that cause it. It appears as a lit zero where it should be dark, or a dark zero that should show, and also as a wrong ripple-out bit on that same digit. Because the decision ripples, one bad digit changes the level its neighbour sees in the same cycle. All codes are swept under each control, and separate digit patterns are applied for each chain direction and for the forced-blank pin, so a fault in a single chain position shows up at once.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;
    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    typedef logic [SEG_W-1:0] seg_t;

    localparam seg_t SEG_DARK = 7'h7F;
    localparam seg_t SEG_LIT  = 7'h00;

    typedef struct packed {
        seg_t seg;
        logic rbo;
    } digit_out_t;

    // Lit mask (1 = lit), bit 0 = a .. bit 6 = g.
    function automatic seg_t glyph_mask(input logic [BCD_W-1:0] code);
        seg_t m;
        case (code)
            4'd0:    m = 7'h3F;
            4'd1:    m = 7'h06;
            4'd2:    m = 7'h5B;
            4'd3:    m = 7'h4F;
            4'd4:    m = 7'h66;
            4'd5:    m = 7'h6D;
            4'd6:    m = 7'h7D;
            4'd7:    m = 7'h07;
            4'd8:    m = 7'h7F;
            4'd9:    m = 7'h6F;
            default: m = 7'h00;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sevseg_glyph.sv
module sevseg_glyph
    import sevseg_pkg::*;
(
    input  logic [BCD_W-1:0] code_i,
    output seg_t             seg_n_o,
    output logic             zero_o
);
    always_comb begin
        seg_n_o = ~glyph_mask(code_i);
        zero_o  = (code_i == '0);
    end
endmodule

// File: rtl/sevseg_blank_ctrl.sv
module sevseg_blank_ctrl
    import sevseg_pkg::*;
#(
    parameter int DIGITS     = 6,
    parameter int INT_DIGITS = 3,
    parameter bit WIRED_AND  = 1'b1
) (
    input  logic                  lamp_test_n,
    input  logic [DIGITS-1:0]     blank_n,
    input  logic                  rbi_int_n,
    input  logic                  rbi_frac_n,
    input  logic [DIGITS-1:0]     zero,
    input  logic [DIGITS*SEG_W-1:0] glyph_n,
    output logic [DIGITS*SEG_W-1:0] seg_n,
    output logic [DIGITS-1:0]     rbo_n
);
    // Priority: lamp test, blank, ripple zero, plain glyph.
    function automatic digit_out_t decide(
        input logic lt_n, input logic bi_n, input logic rbi_n,
        input logic is_zero, input seg_t glyph
    );
        digit_out_t r;
        if (!lt_n) begin
            r.seg = SEG_LIT;
            r.rbo = 1'b1;
        end else if (!bi_n) begin
            r.seg = SEG_DARK;
            r.rbo = 1'b1;
        end else if (!rbi_n && is_zero) begin
            r.seg = SEG_DARK;
            r.rbo = 1'b0;
        end else begin
            r.seg = glyph;
            r.rbo = 1'b1;
        end
        return r;
    endfunction

    function automatic logic pin_level(input logic own, input logic bi_n);
        return WIRED_AND ? (own & bi_n) : own;
    endfunction

    always_comb begin
        logic [DIGITS-1:0] pin_v;
        logic              rbi_v;
        digit_out_t        dec_v;
        pin_v = '1;
        seg_n = '1;
        // Integer part: ripple travels left to right.
        for (int i = 0; i < INT_DIGITS; i++) begin
            rbi_v = (i == 0) ? rbi_int_n : pin_v[(i == 0) ? 0 : i-1];
            dec_v = decide(lamp_test_n, blank_n[i], rbi_v, zero[i],
                           glyph_n[i*SEG_W +: SEG_W]);
            seg_n[i*SEG_W +: SEG_W] = dec_v.seg;
            pin_v[i] = pin_level(dec_v.rbo, blank_n[i]);
        end
        // Fraction part: ripple travels right to left.
        for (int i = DIGITS-1; i >= INT_DIGITS; i--) begin
            rbi_v = (i == DIGITS-1) ? rbi_frac_n
                                    : pin_v[(i == DIGITS-1) ? i : i+1];
            dec_v = decide(lamp_test_n, blank_n[i], rbi_v, zero[i],
                           glyph_n[i*SEG_W +: SEG_W]);
            seg_n[i*SEG_W +: SEG_W] = dec_v.seg;
            pin_v[i] = pin_level(dec_v.rbo, blank_n[i]);
        end
        rbo_n = pin_v;
    end
endmodule

// File: rtl/sevseg_blank_top.sv
module sevseg_blank_top
    import sevseg_pkg::*;
#(
    parameter int DIGITS     = 6,
    parameter int INT_DIGITS = 3,
    parameter bit WIRED_AND  = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIGITS*BCD_W-1:0] bcd_i,
    input  logic                    lamp_test_n,
    input  logic [DIGITS-1:0]       blank_n,
    input  logic                    rbi_int_n,
    input  logic                    rbi_frac_n,
    output logic [DIGITS*SEG_W-1:0] seg_n_o,
    output logic [DIGITS-1:0]       rbo_n_o
);
    localparam int SEGS_TOTAL = DIGITS * SEG_W;

    typedef struct packed {
        logic [SEGS_TOTAL-1:0] seg;
        logic [DIGITS-1:0]     rbo;
    } row_t;

    logic [SEGS_TOTAL-1:0] glyph_n;
    logic [DIGITS-1:0]     zero;
    logic [SEGS_TOTAL-1:0] ctrl_seg;
    logic [DIGITS-1:0]     ctrl_rbo;
    row_t                  row_d, row_q;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        sevseg_glyph u_glyph (
            .code_i  (bcd_i[g*BCD_W +: BCD_W]),
            .seg_n_o (glyph_n[g*SEG_W +: SEG_W]),
            .zero_o  (zero[g])
        );
    end

    sevseg_blank_ctrl #(
        .DIGITS     (DIGITS),
        .INT_DIGITS (INT_DIGITS),
        .WIRED_AND  (WIRED_AND)
    ) u_ctrl (
        .lamp_test_n (lamp_test_n),
        .blank_n     (blank_n),
        .rbi_int_n   (rbi_int_n),
        .rbi_frac_n  (rbi_frac_n),
        .zero        (zero),
        .glyph_n     (glyph_n),
        .seg_n       (ctrl_seg),
        .rbo_n       (ctrl_rbo)
    );

    always_comb begin
        row_d     = row_q;
        row_d.seg = ctrl_seg;
        row_d.rbo = ctrl_rbo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q.seg <= {DIGITS{SEG_DARK}};
            row_q.rbo <= '1;
        end else begin
            row_q <= row_d;
        end
    end

    assign seg_n_o = row_q.seg;
    assign rbo_n_o = row_q.rbo;
endmodule

// File: rtl/sevseg_blank_chk.sv
module sevseg_blank_chk #(
    parameter int DIGITS     = 6,
    parameter int INT_DIGITS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [DIGITS*4-1:0]   bcd_i,
    input logic                  lamp_test_n,
    input logic [DIGITS-1:0]     blank_n,
    input logic                  rbi_int_n,
    input logic [DIGITS*7-1:0]   seg_n_o,
    input logic [DIGITS-1:0]     rbo_n_o
);
    // R3
    lamp_all_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !lamp_test_n) |-> seg_n_o == '0);

    // R6
    head_zero_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lamp_test_n && blank_n[0] && rbi_int_n && bcd_i[3:0] == 4'd0)
        |-> (seg_n_o[6:0] == 7'h40 && rbo_n_o[0]));

    for (genvar k = 0; k < DIGITS; k++) begin : g_chk
        // R4
        blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && lamp_test_n && !blank_n[k]) |-> seg_n_o[k*7 +: 7] == 7'h7F);
        // R2
        bad_code_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && lamp_test_n && bcd_i[k*4 +: 4] > 4'd9)
            |-> seg_n_o[k*7 +: 7] == 7'h7F);
        // R5
        rbo_low_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n && lamp_test_n) && !rbo_n_o[k]) |-> seg_n_o[k*7 +: 7] == 7'h7F);
        // R3
        lamp_rbo_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && !lamp_test_n && blank_n[k]) |-> rbo_n_o[k]);
    end
endmodule

bind sevseg_blank_top sevseg_blank_chk #(
    .DIGITS     (DIGITS),
    .INT_DIGITS (INT_DIGITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bcd_i       (bcd_i),
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .rbi_int_n   (rbi_int_n),
    .seg_n_o     (seg_n_o),
    .rbo_n_o     (rbo_n_o)
);

// File: tb/sevseg_blank_top_tb.sv
module sevseg_blank_top_tb;
    localparam int D  = 6;
    localparam int NI = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [D*4-1:0] bcd_i = '0;
    logic           lamp_test_n = 1'b1;
    logic [D-1:0]   blank_n = '1;
    logic           rbi_int_n = 1'b1;
    logic           rbi_frac_n = 1'b1;
    logic [D*7-1:0] seg_n_o;
    logic [D-1:0]   rbo_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [D*7-1:0] exp_seg_q[$];
    logic [D-1:0]   exp_rbo_q[$];
    string          tag_q[$];

    always #2.5 clk = ~clk;

    sevseg_blank_top #(.DIGITS(D), .INT_DIGITS(NI), .WIRED_AND(1'b1)) u_dut (
        .clk (clk), .rst_n (rst_n), .bcd_i (bcd_i), .lamp_test_n (lamp_test_n),
        .blank_n (blank_n), .rbi_int_n (rbi_int_n), .rbi_frac_n (rbi_frac_n),
        .seg_n_o (seg_n_o), .rbo_n_o (rbo_n_o)
    );

    function automatic logic [6:0] lit_of(input int c);
        case (c)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    // Independent model of one digit given its ripple-in; returns pin level in rbo.
    task automatic model_digit(input int k, input logic rin,
                               output logic [6:0] s, output logic pin);
        int c;
        logic own;
        c = int'(bcd_i[k*4 +: 4]);
        own = 1'b1;
        if (!lamp_test_n)               s = 7'h00;
        else if (!blank_n[k])           s = 7'h7F;
        else if (!rin && c == 0) begin  s = 7'h7F; own = 1'b0; end
        else                            s = ~lit_of(c);
        pin = own & blank_n[k];
    endtask

    task automatic apply(input logic [D*4-1:0] codes, input logic lt,
                         input logic [D-1:0] bn, input logic ri, input logic rf,
                         input string tag);
        logic [D*7-1:0] es;
        logic [D-1:0]   er;
        logic [6:0]     s;
        logic           p, rin;
        @(negedge clk);
        bcd_i = codes; lamp_test_n = lt; blank_n = bn;
        rbi_int_n = ri; rbi_frac_n = rf;
        for (int k = 0; k < NI; k++) begin
            rin = (k == 0) ? ri : er[k-1];
            model_digit(k, rin, s, p);
            es[k*7 +: 7] = s; er[k] = p;
        end
        for (int k = D-1; k >= NI; k--) begin
            rin = (k == D-1) ? rf : er[k+1];
            model_digit(k, rin, s, p);
            es[k*7 +: 7] = s; er[k] = p;
        end
        exp_seg_q.push_back(es);
        exp_rbo_q.push_back(er);
        tag_q.push_back(tag);
    endtask

    // Monitor: result of inputs driven before an edge is visible just after it.
    always @(posedge clk) begin
        #1;
        if (exp_seg_q.size() > 0) begin
            logic [D*7-1:0] es;
            logic [D-1:0]   er;
            string          t;
            es = exp_seg_q.pop_front();
            er = exp_rbo_q.pop_front();
            t  = tag_q.pop_front();
            n_checks++;
            if (seg_n_o !== es || rbo_n_o !== er) begin
                n_fail++;
                $display("FAIL %s: seg=%h rbo=%b expected seg=%h rbo=%b",
                         t, seg_n_o, rbo_n_o, es, er);
            end
        end
    end

    function automatic logic [D*4-1:0] fill(input int c);
        logic [D*4-1:0] v;
        for (int k = 0; k < D; k++) v[k*4 +: 4] = 4'(c);
        return v;
    endfunction

    initial begin
        string tg;
        repeat (3) @(negedge clk);
        // R10: reset state
        n_checks++;
        if (seg_n_o !== {D{7'h7F}} || rbo_n_o !== '1) begin
            n_fail++;
            $display("FAIL R10: seg=%h rbo=%b expected seg=%h rbo=%b",
                     seg_n_o, rbo_n_o, {D{7'h7F}}, {D{1'b1}});
        end
        rst_n = 1'b1;

        for (int c = 0; c < 16; c++) begin
            tg = (c == 0) ? "R6" : (c > 9) ? "R2" : "R1";
            apply(fill(c), 1'b1, '1, 1'b1, 1'b1, tg);
            apply(fill(c), 1'b0, '1, 1'b0, 1'b0, "R3");
            apply(fill(c), 1'b1, 6'b010110, 1'b1, 1'b1, "R4");
            apply(fill(c), 1'b1, '1, 1'b0, 1'b0, (c == 0) ? "R5" : "R1");
        end
        // digit order 0..5 = 0,3,0 . 0,8,0 -> "30.08"
        apply({4'd0,4'd8,4'd0,4'd0,4'd3,4'd0}, 1'b1, '1, 1'b0, 1'b0, "R7 R8");
        apply({4'd0,4'd0,4'd0,4'd0,4'd0,4'd0}, 1'b1, '1, 1'b0, 1'b0, "R7");
        apply({4'd0,4'd0,4'd0,4'd0,4'd0,4'd0}, 1'b1, '1, 1'b0, 1'b1, "R8");
        apply({4'd0,4'd0,4'd5,4'd0,4'd0,4'd7}, 1'b1, '1, 1'b0, 1'b0, "R7 R8");
        apply({4'd5,4'd0,4'd0,4'd0,4'd2,4'd0}, 1'b1, '1, 1'b0, 1'b0, "R7 R8");
        // R9: forced blank pulls the pin low and suppresses the neighbour zero
        apply({4'd0,4'd6,4'd0,4'd0,4'd0,4'd5}, 1'b1, 6'b111110, 1'b1, 1'b1, "R9");
        apply({4'd5,4'd0,4'd0,4'd0,4'd0,4'd0}, 1'b1, 6'b011111, 1'b1, 1'b1, "R9");
        apply({4'd0,4'd6,4'd0,4'd0,4'd0,4'd5}, 1'b0, 6'b111110, 1'b1, 1'b1, "R3 R9");
        apply({4'd9,4'd8,4'd7,4'd6,4'd5,4'd4}, 1'b1, '1, 1'b1, 1'b1, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule